// File: doc/BRIEF.md
# SPI Dual-Mode Transfer Status Logic

This block keeps the status flags of a byte-wide SPI data path and holds the byte stores behind them. A host writes bytes to send through a write port and takes received bytes from a read port. A built-in byte shifter moves each stored byte out MSB first and, in the same transfer, assembles one incoming byte.

A mode input picks how bytes are stored. In single-unit mode there is one transmit holding slot and one receive holding slot. In sequential mode each direction has a 32-byte FIFO. A three-flag status word reports three conditions: whether the transmit side can take a byte, whether all transmission has finished, and whether received data is ready. In sequential mode the received-data flag means the receive FIFO is completely full. Because of that, no separate receive-full flag exists.

The shifter side is brought out for observation. It shows a load request, a busy indication and a received-byte strobe, together with the serial output and input. Changing the mode discards everything stored and returns the flags to their reset values.

Top module: `spi_xfer_status`

## Requirements
- R1: Out of reset the status word reads 0x06. Bit 2 is the transmit-space flag (1), bit 1 is the transmit-done flag (1) and bit 0 is the receive-ready flag (0). Bits 7..3 always read 0.
- R2: In single-unit mode (modeSeq=0) the transmit-space flag reads 0 from the cycle after a byte is accepted into the empty holding slot. It reads 1 again from the cycle after the shifter takes that byte.
- R3: In sequential mode (modeSeq=1) the transmit-space flag reads 1 while the transmit FIFO holds fewer than 32 bytes and 0 when it holds 32.
- R4: The transmit-done flag reads 0 while a byte is stored for transmit, a load request is pending or the shifter is busy. It reads 1 once all stores are empty and the last bit has shifted.
- R5: In single-unit mode the receive-ready flag goes to 1 in the cycle after the received-byte strobe, and rdData shows the byte. It returns to 0 in the cycle after a read.
- R6: In sequential mode the receive-ready flag reads 1 only when the receive FIFO holds 32 bytes. It drops to 0 in the cycle after a single read.
- R7: A write while the transmit-space flag reads 0 is ignored: no byte is stored and no extra transfer happens. A read while no received byte is stored is ignored and leaves the stores unchanged.
- R8: A change of modeSeq empties both stores, stops any transfer in progress and makes the status word read 0x06 in the next cycle.
- R9: The load request is asserted in the cycle after a byte becomes available while the shifter is idle. The shifter takes the byte at the next edge. It then stays busy for 8 cycles. The received-byte strobe is high in the last busy cycle.
- R10: A byte that completes while the receive store is full is discarded. The stored bytes are kept.
- R11: Bytes are sent MSB first on sdo and leave the receive store in the order they were written. With sdo looped back to sdi, each received byte equals the byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSeq | input | 1 | 0 = single-unit mode, 1 = sequential (FIFO) mode |
| wrEn | input | 1 | Write strobe for a transmit byte |
| wrData | input | 8 | Transmit byte |
| rdEn | input | 1 | Read strobe; removes the oldest received byte |
| rdData | output | 8 | Oldest received byte |
| status | output | 8 | Flags: bit 2 transmit space, bit 1 transmit done, bit 0 receive ready |
| shLoadReq | output | 1 | Shifter load request; the byte is taken at the next edge |
| shBusy | output | 1 | Shifter is moving a byte |
| shRxStrobe | output | 1 | One-cycle strobe marking a completed received byte |
| sdo | output | 1 | Serial data out, MSB first |
| sdi | input | 1 | Serial data in |

## Verification
A wrong store count shows up in the space and ready flags at the very next sample. Each occupancy change is tracked in the bench and compared cycle by cycle. A corrupted pointer or a lost byte appears only when bytes come out of the receive store, so the bench drains a full FIFO and compares all 32 bytes in order. Shifter timing errors show as a wrong busy length or a misplaced strobe within one transfer, about ten cycles. A flush that misses a store shows as a status word other than 0x06 one cycle after the mode change.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  // strobes from control to datapath, one per datapath action
  typedef struct packed {
    logic flush;
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic shLoad;
    logic shShift;
  } xfer_strobe_t;

  typedef enum logic {
    SH_IDLE  = 1'b0,
    SH_SHIFT = 1'b1
  } sh_state_e;

endpackage

// File: rtl/spi_xfer_fifo.sv
module spi_xfer_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/spi_xfer_dpath.sv
module spi_xfer_dpath import spi_xfer_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xfer_strobe_t      stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);

  logic [DATA_W-1:0] txHead;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] rxByte;

  spi_xfer_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (stb.flush),
    .push   (stb.txPush),
    .pop    (stb.txPop),
    .wrData (wrData),
    .rdData (txHead),
    .count  (txCount)
  );

  // shift register: loads from the transmit store, rotates in sdi
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (stb.flush) begin
      shReg <= '0;
    end else if (stb.shLoad) begin
      shReg <= txHead;
    end else if (stb.shShift) begin
      shReg <= {shReg[DATA_W-2:0], sdi};
    end
  end

  assign sdo    = shReg[DATA_W-1];
  assign rxByte = {shReg[DATA_W-2:0], sdi};

  spi_xfer_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (stb.flush),
    .push   (stb.rxPush),
    .pop    (stb.rxPop),
    .wrData (rxByte),
    .rdData (rdData),
    .count  (rxCount)
  );

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl import spi_xfer_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int STAT_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSeq,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  output xfer_strobe_t      stb,
  output logic [STAT_W-1:0] status,
  output logic              shLoadReq,
  output logic              shBusy,
  output logic              shRxStrobe
);

  logic             modeQ;
  sh_state_e        state;
  logic [BIT_W-1:0] bitCnt;
  logic             flush;
  logic [CNT_W-1:0] cap;
  logic             txRoom;
  logic             rxRoom;
  logic             idle;
  logic             lastBit;
  logic             tempFlag;
  logic             tendFlag;
  logic             rendFlag;

  // a mode change seen at the input flushes at the coming edge
  assign flush   = (modeSeq != modeQ);
  assign cap     = modeQ ? CNT_W'(DEPTH) : CNT_W'(1);
  assign txRoom  = (txCount < cap);
  assign rxRoom  = (rxCount < cap);
  assign idle    = (state == SH_IDLE);
  assign lastBit = (state == SH_SHIFT) && (bitCnt == BIT_W'(DATA_W - 1));

  always_comb begin
    stb         = '0;
    stb.flush   = flush;
    stb.txPush  = wrEn && txRoom && !flush;
    stb.txPop   = idle && (txCount != '0) && !flush;
    stb.shLoad  = stb.txPop;
    stb.shShift = !idle && !flush;
    stb.rxPush  = lastBit && rxRoom && !flush;
    stb.rxPop   = rdEn && (rxCount != '0) && !flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      state  <= SH_IDLE;
      bitCnt <= '0;
    end else begin
      modeQ <= modeSeq;
      if (flush) begin
        state  <= SH_IDLE;
        bitCnt <= '0;
      end else if (idle) begin
        if (stb.txPop) begin
          state  <= SH_SHIFT;
          bitCnt <= '0;
        end
      end else if (lastBit) begin
        state  <= SH_IDLE;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign tempFlag   = txRoom;
  assign tendFlag   = (txCount == '0) && idle;
  assign rendFlag   = !rxRoom;
  assign status     = STAT_W'({tempFlag, tendFlag, rendFlag});
  assign shLoadReq  = stb.txPop;
  assign shBusy     = !idle;
  assign shRxStrobe = lastBit;

endmodule

// File: rtl/spi_xfer_status.sv
module spi_xfer_status import spi_xfer_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSeq,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] status,
  output logic              shLoadReq,
  output logic              shBusy,
  output logic              shRxStrobe,
  output logic              sdo,
  input  logic              sdi
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  xfer_strobe_t     stb;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;

  spi_xfer_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .STAT_W(STAT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSeq    (modeSeq),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .stb        (stb),
    .status     (status),
    .shLoadReq  (shLoadReq),
    .shBusy     (shBusy),
    .shRxStrobe (shRxStrobe)
  );

  spi_xfer_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .sdi     (sdi),
    .sdo     (sdo),
    .rdData  (rdData),
    .txCount (txCount),
    .rxCount (rxCount)
  );

endmodule

// File: rtl/spi_xfer_status_chk.sv
module spi_xfer_status_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeSeq,
  input logic              wrEn,
  input logic              rdEn,
  input logic [STAT_W-1:0] status,
  input logic              shLoadReq,
  input logic              shBusy,
  input logic              shRxStrobe
);

  localparam logic [STAT_W-1:0] IDLE_WORD = STAT_W'(3'b110);

  // R1: first cycle out of reset shows the reset flags
  p_reset_flags_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> status == IDLE_WORD);

  // R1: unused status bits stay low
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    status[STAT_W-1:3] == '0);

  // R2: accepted write into the empty slot clears transmit space
  p_temp_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSeq && !$past(modeSeq) && wrEn && status[2]) |=> !status[2]);

  // R4: pending load or active shift means transmit not done
  p_busy_tend_r4: assert property (@(posedge clk) disable iff (!rstN)
    (shBusy || shLoadReq) |-> !status[1]);

  // R5: a completed byte in single-unit mode raises receive ready
  p_rend_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSeq && !$past(modeSeq) && shRxStrobe && !rdEn) |=> status[0]);

  // R6: one read from a full receive FIFO drops receive ready
  p_rend_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSeq && $past(modeSeq) && rdEn && status[0]) |=> !status[0]);

  // R8: a mode change returns the flags to the reset word
  p_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSeq != $past(modeSeq)) |=> status == IDLE_WORD);

  // R9: a load request is followed by a busy shifter
  p_load_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    shLoadReq |=> shBusy);

  // R9: the receive strobe only occurs inside a busy window
  p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    shRxStrobe |-> shBusy);

endmodule

bind spi_xfer_status spi_xfer_status_chk #(.STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeSeq    (modeSeq),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .status     (status),
  .shLoadReq  (shLoadReq),
  .shBusy     (shBusy),
  .shRxStrobe (shRxStrobe)
);

// File: tb/tb_spi_xfer_status.sv
`timescale 1ns/1ps
module tb_spi_xfer_status;

  logic       clk = 1'b0;
  logic       rstN;
  logic       modeSeq;
  logic       wrEn;
  logic [7:0] wrData;
  logic       rdEn;
  logic [7:0] rdData;
  logic [7:0] status;
  logic       shLoadReq;
  logic       shBusy;
  logic       shRxStrobe;
  logic       sdo;
  logic       sdi;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;
  assign sdi = sdo;  // loopback

  spi_xfer_status dut (
    .clk(clk), .rstN(rstN), .modeSeq(modeSeq), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .status(status), .shLoadReq(shLoadReq),
    .shBusy(shBusy), .shRxStrobe(shRxStrobe), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    wrData = d;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic readByte();
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitDone(output int strobes);
    strobes = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (shRxStrobe) strobes++;
      if (status[1]) break;
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(status == 8'h06, "R1 reset status word", status, 8'h06);
  endtask

  task automatic tSingleBasic();
    int busyCnt;
    bit lastStrobe;
    writeByte(8'hA5);
    chk(status[2] == 1'b0, "R2 space flag after write", status[2], 0);
    chk(status[1] == 1'b0, "R4 done flag after write", status[1], 0);
    chk(shLoadReq == 1'b1, "R9 load request", shLoadReq, 1);
    @(negedge clk);
    chk(shBusy == 1'b1, "R9 busy after load", shBusy, 1);
    chk(status[2] == 1'b1, "R2 space flag after take", status[2], 1);
    busyCnt    = 1;
    lastStrobe = shRxStrobe;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!shBusy) break;
      busyCnt++;
      lastStrobe = shRxStrobe;
    end
    chk(busyCnt == 8, "R9 busy length", busyCnt, 8);
    chk(lastStrobe == 1'b1, "R9 strobe in last busy cycle", lastStrobe, 1);
    chk(status[0] == 1'b1, "R5 ready after receive", status[0], 1);
    chk(status[1] == 1'b1, "R4 done after shift", status[1], 1);
    chk(rdData == 8'hA5, "R11 loopback byte", rdData, 8'hA5);
    readByte();
    chk(status[0] == 1'b0, "R5 ready cleared by read", status[0], 0);
  endtask

  task automatic tSingleOverflow();
    int s;
    wrData = 8'h11;
    wrEn   = 1'b1;
    @(negedge clk);
    wrData = 8'h22;  // holding slot occupied: must be ignored
    @(negedge clk);
    wrEn = 1'b0;
    waitDone(s);
    chk(s == 1, "R7 ignored write makes no transfer", s, 1);
    chk(rdData == 8'h11, "R7 first byte kept", rdData, 8'h11);
    readByte();
    chk(status == 8'h06, "R5 idle after read", status, 8'h06);
  endtask

  task automatic tSingleDiscard();
    int s;
    writeByte(8'h33);
    waitDone(s);
    writeByte(8'h44);
    waitDone(s);
    chk(status[0] == 1'b1, "R10 ready held", status[0], 1);
    chk(rdData == 8'h33, "R10 older byte kept", rdData, 8'h33);
    readByte();
    chk(status[0] == 1'b0, "R10 nothing left after read", status[0], 0);
    readByte();  // empty read ignored
    writeByte(8'h55);
    waitDone(s);
    chk(rdData == 8'h55, "R7 empty read left store intact", rdData, 8'h55);
    readByte();
  endtask

  task automatic tSeqFill();
    int occ, rxOcc, acc, ignored, strobes, tempBad, rendBad;
    bit sawFull, writing;
    modeSeq = 1'b1;
    @(negedge clk);
    chk(status == 8'h06, "R8 flush on entry to sequential", status, 8'h06);
    occ = 0; rxOcc = 0; acc = 0; ignored = 0; strobes = 0;
    tempBad = 0; rendBad = 0; sawFull = 0; writing = 1;
    for (int k = 0; k < 3000; k++) begin
      // sample
      if (status[2] != (occ < 32)) tempBad++;
      if (status[0] != (rxOcc == 32)) rendBad++;
      if (!status[2]) sawFull = 1;
      if (!writing && status[1]) break;
      // update model for the coming edge
      if (writing) begin
        if (status[2]) acc++; else ignored++;
        if (status[2]) occ++;
      end
      if (shLoadReq) occ--;
      if (shRxStrobe) begin
        strobes++;
        if (rxOcc < 32) rxOcc++;
      end
      // drive
      wrData = 8'h40 + 8'(acc);
      if (writing && status[2]) wrData = 8'h40 + 8'(acc - 1);
      wrEn = writing;
      if (ignored >= 2) begin
        writing = 0;
        wrEn    = 1'b0;
      end
      @(negedge clk);
    end
    wrEn = 1'b0;
    chk(tempBad == 0, "R3 space flag against occupancy", tempBad, 0);
    chk(sawFull == 1, "R3 space flag reached zero", sawFull, 1);
    chk(rendBad == 0, "R6 ready only when 32 held", rendBad, 0);
    chk(strobes == acc, "R7 only accepted bytes transferred", strobes, acc);
    chk(acc > 32, "R10 more bytes sent than stored", acc, 33);
    chk(status[0] == 1'b1, "R6 ready with full FIFO", status[0], 1);
    for (int i = 0; i < 32; i++) begin
      chk(rdData == 8'h40 + 8'(i), "R11 FIFO order", rdData, 8'h40 + 8'(i));
      rdEn = 1'b1;
      @(negedge clk);
      if (i == 0) chk(status[0] == 1'b0, "R6 ready drops after one read", status[0], 0);
    end
    rdEn = 1'b0;
    readByte();  // empty read ignored
    writeByte(8'hC3);
    waitDone(strobes);
    chk(rdData == 8'hC3, "R7 pointers intact after empty read", rdData, 8'hC3);
    chk(status[0] == 1'b0, "R6 one byte is not ready", status[0], 0);
    readByte();
  endtask

  task automatic tFlush();
    int s;
    wrEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      wrData = 8'h70 + 8'(i);
      @(negedge clk);
    end
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    modeSeq = 1'b0;
    @(negedge clk);
    chk(status == 8'h06, "R8 status after mode change", status, 8'h06);
    chk(shBusy == 1'b0, "R8 shift stopped", shBusy, 0);
    s = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (shRxStrobe || shBusy) s++;
    end
    chk(s == 0, "R8 no transfer after flush", s, 0);
    chk(status == 8'h06, "R8 flags stay idle", status, 8'h06);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; modeSeq = 1'b0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tSingleBasic();
    tSingleOverflow();
    tSingleDiscard();
    tSeqFill();
    tFlush();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule